// File: doc/BRIEF.md
# Memory-Mapped Serial Port with One-Byte Buffers

This block is a serial port that a processor reaches through an APB slave interface. It has one transmit wire and one receive wire and no flow-control wires. Each direction holds one byte and has no FIFO. Software loads a byte into the transmit holding register. The shifter takes that byte when it is free and sends it as a frame of one start bit, eight data bits with the least significant bit first, and one stop bit. The receiver samples the line near the middle of each bit and places each complete byte in the receive holding register, where software reads it.

Five word-aligned registers are visible. The data register (0x000) holds the transmit byte on write and the received byte on read. The status register (0x004) holds the buffer-full and overrun flags. The control register (0x008) holds the enables and the test mode. The pending-interrupt register (0x00C) reads the pending flags, and writing to it clears them. The bit-period register (0x010) gives one bit time as a number of clock cycles. Four separate interrupt lines report transmit-empty, receive-full, transmit overrun and receive overrun, and one more line is the OR of those four.

Top module: `apb_serial_port`

## Requirements
- R1: After reset, status, control, pending-interrupt and bit-period registers read 0, the transmit line is high, and every interrupt output is low.
- R2: Control (bits 6:0) and bit-period (DIV_W low bits) read back what was written, and the bits above those widths read as 0.
- R3: A transmitted frame is a low start bit, then the 8 data bits with the LSB first, then a high stop bit. Each bit lasts bit-period cycles, and the line is high whenever no frame is being sent.
- R4: A write to the data register loads the transmit byte and sets status bit 0. The bit stays set until the shifter takes the byte, and the shifter takes a byte only while control bit 0 (transmit enable) is 1.
- R5: Pending bit 0 sets only when the transmit buffer goes from full to empty while control bit 2 is 1. Being empty alone never sets it.
- R6: While control bit 1 (receive enable) is 1, a received frame puts its byte in the data register and sets status bit 1. Reading the data register clears status bit 1. While control bit 1 is 0, no byte is received.
- R7: Pending bit 1 sets when a received byte fills the receive buffer while control bit 3 is 1.
- R8: A write to the data register while status bit 0 is set drops the new byte and sets status bit 2. Pending bit 2 sets if control bit 4 is 1.
- R9: A byte that completes while status bit 1 is set is dropped, and the held byte is kept. Status bit 3 sets, and pending bit 3 sets if control bit 5 is 1.
- R10: Writing 1 to a pending-interrupt bit clears that bit. Writing 1 to status bit 2 or bit 3 clears that overrun flag.
- R11: Each interrupt output is its pending bit ANDed with the matching enable (control bits 2 to 5). The combined output is the OR of the four interrupt outputs.
- R12: While control bit 6 is 1, each transmitted bit lasts one clock cycle, whatever the bit-period value.
- R13: A low pulse on the receive line that has ended before the middle of the start bit is treated as noise and yields no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and serial clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, high at idle |
| irq_tx | output | 1 | Transmit buffer emptied |
| irq_rx | output | 1 | Receive buffer filled |
| irq_tx_ovr | output | 1 | Transmit overrun |
| irq_rx_ovr | output | 1 | Receive overrun |
| irq_any | output | 1 | OR of the four interrupt outputs |

## Verification
A wrong buffer-full flag shows on the status register at the next read. It also shows on the transmit line one cycle after the enable rises: a frame starts when none should, or no frame starts. A wrong bit counter or bit-period counter shows within one frame, because each bit is sampled at its middle and a drift of one cycle per bit moves the later samples onto the wrong bit. A wrong interrupt edge or overrun flag shows on the interrupt outputs and on the pending register at the first read after the event. Received bytes are compared in full, so a fault in shift order or sample point shows as a wrong byte value.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // word index of each register (byte address bits above 1:0)
  localparam int IDX_DATA = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_PEND = 3;
  localparam int IDX_DIV  = 4;

  // control bit positions
  localparam int CB_TX_EN   = 0;
  localparam int CB_RX_EN   = 1;
  localparam int CB_TX_IE   = 2;
  localparam int CB_RX_IE   = 3;
  localparam int CB_TXO_IE  = 4;
  localparam int CB_RXO_IE  = 5;
  localparam int CB_FAST_TX = 6;
  localparam int CTRL_W     = 7;

  typedef enum logic { TXS_IDLE, TXS_SHIFT } tx_state_t;
  typedef enum logic [1:0] { RXS_IDLE, RXS_START, RXS_DATA, RXS_STOP } rx_state_t;
endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/sp_bitclk.sv
// Down-counter giving one tick per bit period; restart loads a first interval.
module sp_bitclk #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] first_len,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == '0);

  always_comb begin
    if (restart)   cnt_d = first_len;
    else if (tick) cnt_d = reload;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_byte,
  input  logic              tick,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME = DATA_W + 2;
  localparam int CW    = $clog2(FRAME + 1);

  tx_state_t        st_q, st_d;
  logic [FRAME-1:0] sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  assign take = (st_q == TXS_IDLE) && enable && buf_full;
  assign busy = (st_q == TXS_SHIFT);
  assign txd  = busy ? sh_q[0] : 1'b1;

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (take) begin
      st_d  = TXS_SHIFT;
      sh_d  = {1'b1, buf_byte, 1'b0};
      cnt_d = CW'(FRAME);
    end else if (busy && tick) begin
      sh_d  = {1'b1, sh_q[FRAME-1:1]};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) st_d = TXS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TXS_IDLE;
      sh_q  <= '1;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rxd,
  input  logic              tick,
  output logic              restart,
  output logic              valid,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CW = $clog2(DATA_W + 1);

  logic              s1_q, line_q;
  rx_state_t         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  assign rx_byte = sh_q;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    restart = 1'b0;
    valid   = 1'b0;
    if (!enable) begin
      st_d = RXS_IDLE;
    end else begin
      case (st_q)
        RXS_IDLE: if (!line_q) begin
          restart = 1'b1;
          st_d    = RXS_START;
        end
        RXS_START: if (tick) begin
          st_d  = line_q ? RXS_IDLE : RXS_DATA;
          cnt_d = '0;
        end
        RXS_DATA: if (tick) begin
          sh_d  = {line_q, sh_q[DATA_W-1:1]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DATA_W - 1)) st_d = RXS_STOP;
        end
        RXS_STOP: if (tick) begin
          valid = line_q;
          st_d  = RXS_IDLE;
        end
        default: st_d = RXS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      line_q <= 1'b1;
      st_q   <= RXS_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= rxd;
      line_q <= s1_q;
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/apb_serial_port.sv
module apb_serial_port
  import sp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIV_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_tx_ovr,
  output logic              irq_rx_ovr,
  output logic              irq_any
);
  localparam int WI = ADDR_W - 2;

  logic rst_n;
  sp_rst_sync u_rst (.clk(pclk), .arst_n(presetn), .rst_n(rst_n));

  // bus decode
  logic          acc_wr, acc_rd, wr_data, rd_data;
  logic [WI-1:0] widx;
  assign widx    = paddr[ADDR_W-1:2];
  assign acc_wr  = psel && penable && pwrite;
  assign acc_rd  = psel && penable && !pwrite;
  assign wr_data = acc_wr && (widx == WI'(IDX_DATA));
  assign rd_data = acc_rd && (widx == WI'(IDX_DATA));

  // architectural state
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] txb_q, txb_d, rxb_q, rxb_d;
  logic              txf_q, txf_d, rxf_q, rxf_d;
  logic              txo_q, txo_d, rxo_q, rxo_d;
  logic [3:0]        pend_q, pend_d;

  // datapath wires
  logic              tx_take, tx_busy, tx_tick, rx_tick, rx_restart, rx_valid;
  logic [DATA_W-1:0] rx_byte;
  logic [DIV_W-1:0]  eff_div, half_div, tx_len, rx_first, rx_len;
  logic              ev_tx_ovr, ev_rx_ovr, ev_rx_fill;
  logic [3:0]        ev, ie;

  assign eff_div  = (div_q == '0) ? DIV_W'(1) : div_q;
  assign half_div = eff_div >> 1;
  assign tx_len   = ctrl_q[CB_FAST_TX] ? '0 : eff_div - 1'b1;
  assign rx_len   = eff_div - 1'b1;
  assign rx_first = (half_div == '0) ? '0 : half_div - 1'b1;

  sp_bitclk #(.W(DIV_W)) u_tx_clk (
    .clk(pclk), .rst_n(rst_n), .restart(tx_take),
    .first_len(tx_len), .reload(tx_len), .tick(tx_tick));

  sp_bitclk #(.W(DIV_W)) u_rx_clk (
    .clk(pclk), .rst_n(rst_n), .restart(rx_restart),
    .first_len(rx_first), .reload(rx_len), .tick(rx_tick));

  sp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(pclk), .rst_n(rst_n), .enable(ctrl_q[CB_TX_EN]),
    .buf_full(txf_q), .buf_byte(txb_q), .tick(tx_tick),
    .take(tx_take), .busy(tx_busy), .txd(txd));

  sp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(pclk), .rst_n(rst_n), .enable(ctrl_q[CB_RX_EN]),
    .rxd(rxd), .tick(rx_tick), .restart(rx_restart),
    .valid(rx_valid), .rx_byte(rx_byte));

  // events
  assign ev_tx_ovr  = wr_data && txf_q;
  assign ev_rx_ovr  = rx_valid && rxf_q && !rd_data;
  assign ev_rx_fill = rx_valid && !ev_rx_ovr;
  assign ev = {ev_rx_ovr, ev_tx_ovr, ev_rx_fill, tx_take};
  assign ie = {ctrl_q[CB_RXO_IE], ctrl_q[CB_TXO_IE], ctrl_q[CB_RX_IE], ctrl_q[CB_TX_IE]};

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    txb_d  = txb_q;
    txf_d  = txf_q;
    rxb_d  = rxb_q;
    rxf_d  = rxf_q;
    txo_d  = txo_q;
    rxo_d  = rxo_q;
    pend_d = pend_q;

    if (acc_wr && widx == WI'(IDX_CTRL)) ctrl_d = pwdata[CTRL_W-1:0];
    if (acc_wr && widx == WI'(IDX_DIV))  div_d  = pwdata[DIV_W-1:0];

    // clears first, sets below take priority
    if (acc_wr && widx == WI'(IDX_STAT)) begin
      if (pwdata[2]) txo_d = 1'b0;
      if (pwdata[3]) rxo_d = 1'b0;
    end
    if (acc_wr && widx == WI'(IDX_PEND)) pend_d = pend_q & ~pwdata[3:0];
    if (tx_take) txf_d = 1'b0;
    if (rd_data) rxf_d = 1'b0;

    if (wr_data && !txf_q) begin
      txb_d = pwdata[DATA_W-1:0];
      txf_d = 1'b1;
    end
    if (ev_tx_ovr) txo_d = 1'b1;
    if (ev_rx_fill) begin
      rxb_d = rx_byte;
      rxf_d = 1'b1;
    end
    if (ev_rx_ovr) rxo_d = 1'b1;
    pend_d = pend_d | (ev & ie);
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      txb_q  <= '0;
      txf_q  <= 1'b0;
      rxb_q  <= '0;
      rxf_q  <= 1'b0;
      txo_q  <= 1'b0;
      rxo_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      txb_q  <= txb_d;
      txf_q  <= txf_d;
      rxb_q  <= rxb_d;
      rxf_q  <= rxf_d;
      txo_q  <= txo_d;
      rxo_q  <= rxo_d;
      pend_q <= pend_d;
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    case (widx)
      WI'(IDX_DATA): prdata[DATA_W-1:0] = rxb_q;
      WI'(IDX_STAT): prdata[3:0]        = {rxo_q, txo_q, rxf_q, txf_q};
      WI'(IDX_CTRL): prdata[CTRL_W-1:0] = ctrl_q;
      WI'(IDX_PEND): prdata[3:0]        = pend_q;
      WI'(IDX_DIV):  prdata[DIV_W-1:0]  = div_q;
      default:       prdata = '0;
    endcase
  end

  logic [3:0] irq_vec;
  assign irq_vec    = pend_q & ie;
  assign irq_tx     = irq_vec[0];
  assign irq_rx     = irq_vec[1];
  assign irq_tx_ovr = irq_vec[2];
  assign irq_rx_ovr = irq_vec[3];
  assign irq_any    = |irq_vec;
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_full,
  input logic       rx_full,
  input logic       tx_ovr,
  input logic [3:0] pend,
  input logic       wr_data,
  input logic       rx_valid,
  input logic       tx_busy,
  input logic       txd
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R3

  AST_TX_INT_ON_EMPTY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> ($past(tx_full) && !tx_full)); // R5

  AST_RX_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_valid)); // R6

  AST_RX_INT_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> rx_full); // R7

  AST_TX_OVR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full) |=> tx_ovr); // R8
endmodule

bind apb_serial_port sp_checker u_chk (
  .clk(pclk), .rst_n(rst_n), .tx_full(txf_q), .rx_full(rxf_q),
  .tx_ovr(txo_q), .pend(pend_q), .wr_data(wr_data),
  .rx_valid(rx_valid), .tx_busy(tx_busy), .txd(txd));

// File: tb/apb_serial_port_bench.sv
`timescale 1ns/1ps
module apb_serial_port_bench;
  localparam int ADDR_W = 12;
  localparam int BIT    = 8;

  logic              pclk, presetn, psel, penable, pwrite, rxd;
  logic [ADDR_W-1:0] paddr;
  logic [31:0]       pwdata, prdata;
  logic txd, irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any;

  int n_tests = 0;
  int n_fail  = 0;

  apb_serial_port u_apb_serial_port (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_tx_ovr(irq_tx_ovr), .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any));

  initial pclk = 1'b0;
  always #4 pclk = ~pclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apb_rd(a, v);
    check(req, v, exp);
  endtask

  // captures one frame, sampling every bit at its middle
  task automatic grab_frame(input int bit_cycles, output logic [9:0] bits);
    int t = 0;
    bits = '0;
    while (txd !== 1'b0 && t < 5000) begin
      @(negedge pclk);
      t++;
    end
    repeat (bit_cycles / 2) @(negedge pclk);
    for (int i = 0; i < 10; i++) begin
      bits[i] = txd;
      repeat (bit_cycles) @(negedge pclk);
    end
  endtask

  task automatic drive_frame(input logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge pclk);
      rxd = f[i];
      repeat (BIT - 1) @(negedge pclk);
    end
    repeat (4) @(negedge pclk);
  endtask

  task automatic t_reset;
    check("R1 txd idle", {31'b0, txd}, 32'h1);
    check("R1 irq_any", {31'b0, irq_any}, 32'h0);
    rd_check("R1 status", 12'h004, 32'h0);
    rd_check("R1 control", 12'h008, 32'h0);
    rd_check("R1 pending", 12'h00C, 32'h0);
    rd_check("R1 bit-period", 12'h010, 32'h0);
  endtask

  task automatic t_regs;
    apb_wr(12'h008, 32'hFFFF_FF38);
    rd_check("R2 control readback", 12'h008, 32'h38);
    apb_wr(12'h010, 32'hFFFA_BCDE);
    rd_check("R2 bit-period readback", 12'h010, 32'hABCDE);
    apb_wr(12'h008, 32'h0);
    apb_wr(12'h010, BIT);
    rd_check("R2 bit-period set", 12'h010, BIT);
  endtask

  task automatic t_tx_irq;
    logic [9:0] f;
    apb_wr(12'h008, 32'h04);
    rd_check("R5 empty alone no pending", 12'h00C, 32'h0);
    apb_wr(12'h000, 32'h3C);
    rd_check("R4 full held while disabled", 12'h004, 32'h1);
    rd_check("R5 no pending before take", 12'h00C, 32'h0);
    apb_wr(12'h008, 32'h05);
    grab_frame(BIT, f);
    check("R3 frame 0x3C", {22'b0, f}, {22'b0, 1'b1, 8'h3C, 1'b0});
    rd_check("R4 full cleared after take", 12'h004, 32'h0);
    rd_check("R5 pending after empty edge", 12'h00C, 32'h1);
    check("R11 irq_tx", {31'b0, irq_tx}, 32'h1);
    check("R11 irq_any", {31'b0, irq_any}, 32'h1);
    apb_wr(12'h00C, 32'h1);
    rd_check("R10 pending cleared", 12'h00C, 32'h0);
    check("R11 irq_any low", {31'b0, irq_any}, 32'h0);
    apb_wr(12'h008, 32'h01);
    apb_wr(12'h000, 32'h81);
    grab_frame(BIT, f);
    check("R3 frame 0x81", {22'b0, f}, {22'b0, 1'b1, 8'h81, 1'b0});
    rd_check("R5 no pending while disabled", 12'h00C, 32'h0);
    repeat (BIT) @(negedge pclk);
  endtask

  task automatic t_tx_ovr;
    logic [9:0] f;
    apb_wr(12'h008, 32'h10);
    apb_wr(12'h000, 32'h11);
    apb_wr(12'h000, 32'h22);
    rd_check("R8 status overrun", 12'h004, 32'h5);
    rd_check("R8 pending overrun", 12'h00C, 32'h4);
    check("R11 irq_tx_ovr", {31'b0, irq_tx_ovr}, 32'h1);
    apb_wr(12'h008, 32'h11);
    grab_frame(BIT, f);
    check("R8 first byte kept", {22'b0, f}, {22'b0, 1'b1, 8'h11, 1'b0});
    apb_wr(12'h004, 32'h4);
    rd_check("R10 overrun flag cleared", 12'h004, 32'h0);
    apb_wr(12'h00C, 32'h4);
    rd_check("R10 overrun pending cleared", 12'h00C, 32'h0);
    repeat (BIT) @(negedge pclk);
  endtask

  task automatic t_fast;
    logic [9:0] f;
    apb_wr(12'h008, 32'h41);
    apb_wr(12'h000, 32'h96);
    grab_frame(1, f);
    check("R12 one-cycle bits", {22'b0, f}, {22'b0, 1'b1, 8'h96, 1'b0});
    apb_wr(12'h008, 32'h0);
  endtask

  task automatic t_rx;
    apb_wr(12'h008, 32'h0A);
    drive_frame(8'h5A);
    rd_check("R6 receive full", 12'h004, 32'h2);
    rd_check("R7 receive pending", 12'h00C, 32'h2);
    check("R11 irq_rx", {31'b0, irq_rx}, 32'h1);
    rd_check("R6 received byte", 12'h000, 32'h5A);
    rd_check("R6 full cleared by read", 12'h004, 32'h0);
    apb_wr(12'h00C, 32'h2);
    apb_wr(12'h008, 32'h0);
    drive_frame(8'hC3);
    rd_check("R6 receive disabled ignores frame", 12'h004, 32'h0);
  endtask

  task automatic t_rx_ovr;
    apb_wr(12'h008, 32'h22);
    drive_frame(8'h12);
    drive_frame(8'h34);
    rd_check("R9 status overrun", 12'h004, 32'hA);
    rd_check("R9 pending overrun", 12'h00C, 32'h8);
    check("R11 irq_rx_ovr", {31'b0, irq_rx_ovr}, 32'h1);
    rd_check("R9 first byte kept", 12'h000, 32'h12);
    apb_wr(12'h004, 32'h8);
    rd_check("R10 receive overrun cleared", 12'h004, 32'h0);
    apb_wr(12'h00C, 32'h8);
  endtask

  task automatic t_glitch;
    apb_wr(12'h008, 32'h02);
    @(negedge pclk) rxd = 1'b0;
    repeat (2) @(negedge pclk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge pclk);
    rd_check("R13 short pulse rejected", 12'h004, 32'h0);
    drive_frame(8'h77);
    rd_check("R13 receiver still works", 12'h000, 32'h77);
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; rxd = 1'b1;
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);
    t_reset;
    t_regs;
    t_tx_irq;
    t_tx_ovr;
    t_fast;
    t_rx;
    t_rx_ovr;
    t_glitch;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule